// File: doc/BRIEF.md
# Next Program Counter Unit

This block owns the program counter of a simple 32-bit load-store processor and picks the address of the next instruction on every clock. By default it steps to the following word. It also redirects the flow for compare-and-branch instructions (taken on equal or on not-equal), absolute jumps, jump-with-link, and jumps through a register.

The decoded fields of the instruction at the current PC arrive on the inputs in the same cycle: the opcode, the 16-bit immediate field and the 26-bit jump field. The execute stage supplies the equality result of the two compared registers. A register value supplies the target of a register-indirect jump. The new PC appears after the next rising clock edge.

For the link step, the block gives the return address (current PC plus 4) and a write strobe. Both are aimed at register 31, so the register file can record where a called procedure must return. Instruction memory, hazards and delay slots are handled elsewhere.

Top module: `pc_sequencer`

## Requirements
- R1: A synchronous active-high reset `rst` sets `pcOut` to 0x00000000 at the next rising edge, including when it is asserted in the middle of a run.
- R2: Any opcode other than 2, 3, 4 and 5, and other than 0 combined with function code 8, advances `pcOut` by 4 at each rising edge.
- R3: Opcode 4 (branch-if-equal) with `operandsEqual`=1 loads `pcOut + 4 + (sign-extended offsetField << 2)`.
- R4: Opcode 4 with `operandsEqual`=0 loads `pcOut + 4`.
- R5: Opcode 5 (branch-if-not-equal) with `operandsEqual`=0 loads the branch target of R3, and with `operandsEqual`=1 it loads `pcOut + 4`.
- R6: The branch offset is a signed 16-bit count of instructions. Offsets 0x7FFF, 0x8000 and 0xFFFF reach +32767, -32768 and -1 instructions from `pcOut + 4`.
- R7: Opcode 2 (jump) loads the top 4 bits of `pcOut + 4`, followed by `jumpField`, followed by two zero bits.
- R8: Opcode 3 (jump-with-link) jumps as in R7. In that same cycle it raises `linkWrite`, with `linkValue` = `pcOut + 4` and `linkDest` = 31.
- R9: `linkWrite` is 0 for every opcode other than 3, and while reset is held.
- R10: Opcode 0 with function code 8 in `offsetField[5:0]` loads `regTarget` into the PC. Opcode 0 with any other function code ignores `regTarget` and advances by 4.
- R11: The region bits of R7 come from `pcOut + 4`. A jump held at address 0x0FFFFFFC therefore lands in the region 0x1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| opcode | input | 6 | Opcode of the instruction at `pcOut` |
| offsetField | input | 16 | Immediate field; its low 6 bits carry the function code |
| jumpField | input | 26 | Word-address field of jump instructions |
| operandsEqual | input | 1 | 1 when the two compared registers match |
| regTarget | input | 32 | Register value for register-indirect jumps |
| pcOut | output | 32 | Current program counter |
| linkValue | output | 32 | Return address, `pcOut + 4` |
| linkWrite | output | 1 | Write strobe for the return address |
| linkDest | output | 5 | Register index for the return address, 31 |

## Verification
Sequential flow is run with unrelated opcodes, and with opcode 0 carrying a non-jump function code. This separates plain stepping from the register jump, and shows that `regTarget` is ignored there. Both branch types are driven with both equality values, so a swapped condition or an inverted polarity shows up. Positive, negative and extreme offsets expose missing sign extension and missing scaling by 4. Jumps, including one from the last word of a 256 MB region, tell apart the use of `pcOut` and the use of `pcOut + 4` for the region bits, and the link outputs are checked on every instruction kind.

// File: rtl/pcseq_pkg.sv
package pcseq_pkg;

  localparam int OP_W = 6;
  localparam int FN_W = 6;

  localparam logic [OP_W-1:0] OP_SPECIAL = 6'd0;
  localparam logic [OP_W-1:0] OP_JUMP    = 6'd2;
  localparam logic [OP_W-1:0] OP_JLINK   = 6'd3;
  localparam logic [OP_W-1:0] OP_BREQ    = 6'd4;
  localparam logic [OP_W-1:0] OP_BRNE    = 6'd5;
  localparam logic [FN_W-1:0] FN_JREG    = 6'd8;

  typedef enum logic [1:0] {
    SEL_SEQ    = 2'd0,
    SEL_BRANCH = 2'd1,
    SEL_JUMP   = 2'd2,
    SEL_REG    = 2'd3
  } nextSel_e;

  typedef struct packed {
    nextSel_e sel;
    logic     link;
  } pcStrobes_t;

endpackage

// File: rtl/pcseq_ctrl.sv
module pcseq_ctrl
  import pcseq_pkg::*;
(
  input  logic            clk,
  input  logic            rst,
  input  logic [OP_W-1:0] opcode,
  input  logic [FN_W-1:0] functField,
  input  logic            operandsEqual,
  output pcStrobes_t      strobes
);

  logic isJreg;
  assign isJreg = (opcode == OP_SPECIAL) && (functField == FN_JREG);

  always_comb begin
    strobes.sel  = SEL_SEQ;
    strobes.link = 1'b0;
    case (opcode)
      OP_BREQ:  if (operandsEqual)  strobes.sel = SEL_BRANCH;
      OP_BRNE:  if (!operandsEqual) strobes.sel = SEL_BRANCH;
      OP_JUMP:  strobes.sel = SEL_JUMP;
      OP_JLINK: begin
        strobes.sel  = SEL_JUMP;
        strobes.link = !rst;
      end
      default:  if (isJreg) strobes.sel = SEL_REG;
    endcase
  end

  // R4: an equal-branch on unequal operands never redirects
  a_r4_beq_falls_through: assert property (@(posedge clk) disable iff (rst)
    (opcode == OP_BREQ && !operandsEqual) |-> strobes.sel == SEL_SEQ);

  // R5: a not-equal branch on equal operands never redirects
  a_r5_bne_falls_through: assert property (@(posedge clk) disable iff (rst)
    (opcode == OP_BRNE && operandsEqual) |-> strobes.sel == SEL_SEQ);

  // R10: the register path needs opcode 0
  a_r10_reg_needs_special: assert property (@(posedge clk) disable iff (rst)
    (strobes.sel == SEL_REG) |-> opcode == OP_SPECIAL);

endmodule

// File: rtl/pcseq_dpath.sv
module pcseq_dpath
  import pcseq_pkg::*;
#(
  parameter int ADDR_W      = 32,
  parameter int OFF_W       = 16,
  parameter int JMP_W       = 26,
  parameter int INSTR_BYTES = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  pcStrobes_t        strobes,
  input  logic [OFF_W-1:0]  offsetField,
  input  logic [JMP_W-1:0]  jumpField,
  input  logic [ADDR_W-1:0] regTarget,
  output logic [ADDR_W-1:0] pcOut,
  output logic [ADDR_W-1:0] linkValue
);

  localparam int SCALE    = $clog2(INSTR_BYTES);
  localparam int EXT_W    = ADDR_W - OFF_W - SCALE;
  localparam int REGION_W = ADDR_W - JMP_W - SCALE;
  localparam logic [ADDR_W-1:0] STEP = ADDR_W'(INSTR_BYTES);

  logic [ADDR_W-1:0] pcReg;
  logic [ADDR_W-1:0] seqPc;
  logic [ADDR_W-1:0] brDisp;
  logic [ADDR_W-1:0] brPc;
  logic [ADDR_W-1:0] jmpPc;
  logic [ADDR_W-1:0] nextPc;

  assign seqPc  = pcReg + STEP;
  assign brDisp = {{EXT_W{offsetField[OFF_W-1]}}, offsetField, {SCALE{1'b0}}};
  assign brPc   = seqPc + brDisp;

  generate
    if (REGION_W > 0) begin : g_region
      assign jmpPc = {seqPc[ADDR_W-1 -: REGION_W], jumpField, {SCALE{1'b0}}};
    end else begin : g_flat
      assign jmpPc = ADDR_W'({jumpField, {SCALE{1'b0}}});
    end
  endgenerate

  always_comb begin
    case (strobes.sel)
      SEL_BRANCH: nextPc = brPc;
      SEL_JUMP:   nextPc = jmpPc;
      SEL_REG:    nextPc = regTarget;
      default:    nextPc = seqPc;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) pcReg <= '0;
    else     pcReg <= nextPc;
  end

  assign pcOut     = pcReg;
  assign linkValue = seqPc;

  // R1: reset clears the program counter
  a_r1_reset_zero: assert property (@(posedge clk)
    rst |=> pcOut == '0);

  // R2: sequential flow steps one instruction
  a_r2_seq_step: assert property (@(posedge clk) disable iff (rst)
    (strobes.sel == SEL_SEQ) |=> pcOut == $past(pcOut) + STEP);

  // R10: register jump lands on the supplied value
  a_r10_reg_target: assert property (@(posedge clk) disable iff (rst)
    (strobes.sel == SEL_REG) |=> pcOut == $past(regTarget));

  // R8: the link value is the return address of the step just taken
  a_r8_link_is_return: assert property (@(posedge clk) disable iff (rst)
    (strobes.sel == SEL_SEQ) |=> $past(linkValue) == pcOut);

endmodule

// File: rtl/pc_sequencer.sv
module pc_sequencer
  import pcseq_pkg::*;
#(
  parameter int ADDR_W   = 32,
  parameter int OFF_W    = 16,
  parameter int JMP_W    = 26,
  parameter int REG_IDX_W = 5,
  parameter int LINK_REG = 31
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [OP_W-1:0]      opcode,
  input  logic [OFF_W-1:0]     offsetField,
  input  logic [JMP_W-1:0]     jumpField,
  input  logic                 operandsEqual,
  input  logic [ADDR_W-1:0]    regTarget,
  output logic [ADDR_W-1:0]    pcOut,
  output logic [ADDR_W-1:0]    linkValue,
  output logic                 linkWrite,
  output logic [REG_IDX_W-1:0] linkDest
);

  pcStrobes_t strobes;

  pcseq_ctrl u_ctrl (
    .clk           (clk),
    .rst           (rst),
    .opcode        (opcode),
    .functField    (offsetField[FN_W-1:0]),
    .operandsEqual (operandsEqual),
    .strobes       (strobes)
  );

  pcseq_dpath #(
    .ADDR_W      (ADDR_W),
    .OFF_W       (OFF_W),
    .JMP_W       (JMP_W),
    .INSTR_BYTES (4)
  ) u_dpath (
    .clk         (clk),
    .rst         (rst),
    .strobes     (strobes),
    .offsetField (offsetField),
    .jumpField   (jumpField),
    .regTarget   (regTarget),
    .pcOut       (pcOut),
    .linkValue   (linkValue)
  );

  assign linkWrite = strobes.link;
  assign linkDest  = REG_IDX_W'(LINK_REG);

  // R9: the link strobe stays low during reset
  a_r9_no_link_in_reset: assert property (@(posedge clk)
    rst |-> !linkWrite);

  // R8: a link write is followed by a jump to the word address
  a_r8_link_then_jump: assert property (@(posedge clk) disable iff (rst)
    linkWrite |=> pcOut[JMP_W+1:0] == {$past(jumpField), 2'b00});

endmodule

// File: tb/pc_sequencer_test.sv
module pc_sequencer_test;

  localparam time CLK_PERIOD = 10ns;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [5:0]  opcode = 6'h23;
  logic [15:0] offsetField = '0;
  logic [25:0] jumpField = '0;
  logic        operandsEqual = 1'b0;
  logic [31:0] regTarget = '0;
  logic [31:0] pcOut;
  logic [31:0] linkValue;
  logic        linkWrite;
  logic [4:0]  linkDest;

  int checks = 0;
  int fails = 0;
  logic [31:0] expPc;

  always #(CLK_PERIOD/2) clk = ~clk;

  pc_sequencer uut (
    .clk(clk), .rst(rst), .opcode(opcode), .offsetField(offsetField),
    .jumpField(jumpField), .operandsEqual(operandsEqual), .regTarget(regTarget),
    .pcOut(pcOut), .linkValue(linkValue), .linkWrite(linkWrite), .linkDest(linkDest)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] brTarget(input logic [31:0] pc, input logic [15:0] off);
    return pc + 32'd4 + ({{16{off[15]}}, off} * 32'd4);
  endfunction

  // Apply one instruction at the current negedge, check link outputs, clock it in
  task automatic issue(input string req, input logic [5:0] op, input logic [15:0] off,
                       input logic [25:0] jf, input logic eq, input logic [31:0] rt,
                       input logic [31:0] nextExp, input logic expLink);
    opcode = op; offsetField = off; jumpField = jf; operandsEqual = eq; regTarget = rt;
    #1;
    check({req, " link strobe (R9)"}, {31'd0, linkWrite}, {31'd0, expLink});
    if (expLink) begin
      check("R8 link value", linkValue, expPc + 32'd4);
      check("R8 link dest", {27'd0, linkDest}, 32'd31);
    end
    @(posedge clk); @(negedge clk);
    expPc = nextExp;
    check(req, pcOut, expPc);
  endtask

  task automatic doReset();
    rst = 1'b1; opcode = 6'h23;
    @(posedge clk); @(negedge clk);
    check("R9 no link in reset", {31'd0, linkWrite}, 32'd0);
    rst = 1'b0;
    expPc = 32'd0;
    check("R1 reset pc", pcOut, 32'd0);
  endtask

  task automatic testSequential();
    for (int i = 0; i < 3; i++)
      issue("R2 sequential", 6'h23, 16'h1234, 26'h3, 1'b1, 32'hDEAD0000, expPc + 32'd4, 1'b0);
    issue("R2 sequential other op", 6'h08, 16'hFFFF, 26'h0, 1'b0, 32'h0, expPc + 32'd4, 1'b0);
  endtask

  task automatic testBranches();
    issue("R3 beq taken", 6'd4, 16'h0010, 26'h0, 1'b1, 32'h0, brTarget(expPc, 16'h0010), 1'b0);
    issue("R4 beq not taken", 6'd4, 16'h0010, 26'h0, 1'b0, 32'h0, expPc + 32'd4, 1'b0);
    issue("R5 bne taken", 6'd5, 16'h0003, 26'h0, 1'b0, 32'h0, brTarget(expPc, 16'h0003), 1'b0);
    issue("R5 bne not taken", 6'd5, 16'h0003, 26'h0, 1'b1, 32'h0, expPc + 32'd4, 1'b0);
  endtask

  task automatic testOffsets();
    issue("R6 offset -1", 6'd4, 16'hFFFF, 26'h0, 1'b1, 32'h0, expPc, 1'b0);
    issue("R6 offset max", 6'd4, 16'h7FFF, 26'h0, 1'b1, 32'h0, brTarget(expPc, 16'h7FFF), 1'b0);
    issue("R6 offset min", 6'd5, 16'h8000, 26'h0, 1'b0, 32'h0, brTarget(expPc, 16'h8000), 1'b0);
  endtask

  task automatic testJumps();
    logic [31:0] pc4;
    pc4 = expPc + 32'd4;
    issue("R7 jump", 6'd2, 16'h0, 26'h0ABCDE, 1'b0, 32'h0, {pc4[31:28], 26'h0ABCDE, 2'b00}, 1'b0);
    pc4 = expPc + 32'd4;
    issue("R8 jal", 6'd3, 16'h0, 26'h1234567, 1'b0, 32'h0, {pc4[31:28], 26'h1234567, 2'b00}, 1'b1);
  endtask

  task automatic testRegJump();
    issue("R10 jr", 6'd0, 16'h0008, 26'h0, 1'b0, 32'h0FFFFFFC, 32'h0FFFFFFC, 1'b0);
    issue("R11 jump at region edge", 6'd2, 16'h0, 26'h10, 1'b0, 32'h0, 32'h10000040, 1'b0);
    issue("R10 non-jr special ignores reg", 6'd0, 16'h0020, 26'h0, 1'b1, 32'h55555554,
          expPc + 32'd4, 1'b0);
  endtask

  task automatic testMidReset();
    rst = 1'b1;
    @(posedge clk); @(negedge clk);
    expPc = 32'd0;
    check("R1 mid-run reset", pcOut, 32'd0);
    rst = 1'b0;
    issue("R2 after reset", 6'h23, 16'h0, 26'h0, 1'b0, 32'h0, 32'd4, 1'b0);
  endtask

  initial begin
    expPc = 32'd0;
    @(negedge clk);
    doReset();
    testSequential();
    testBranches();
    testOffsets();
    testJumps();
    testRegJump();
    testMidReset();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 5000);
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule